// File: doc/BRIEF.md
# Event Timestamp Latency Meter

This block measures, in clock cycles, how long a piece of logic takes to finish its work. It runs on the same clock as the logic it watches, so no clock-domain crossing is needed. A cycle counter runs all the time, and a lagged copy of it is visible at the output. The counter is sampled only when the watched logic pulses `start_pulse` or `done_pulse`. From those samples the block derives two values: the processing latency, which is done minus start, and the repetition interval, which is the time from one start to the next.

At most one start can be outstanding at a time. A second start that arrives before the first has completed is dropped and raises a sticky overlap flag. A done that arrives with no start outstanding is dropped and raises a sticky orphan flag. Results leave the block as a one-cycle `result_valid` strobe. There is no `ready` input and no back-pressure: a consumer that wants a result must capture it in the cycle the strobe is high. The latched values stay stable until the next accepted event changes them.

All differences are taken modulo 2^CNT_W. A measurement that spans a single counter wrap therefore still comes out correct.

Top module: `latency_meter`

## Requirements
- R1: After reset, `count_out` is 0 through the first clock edge with reset low. After the k-th such edge (k counted from 0) it shows k mod 2^CNT_W, so it lags the internal counter by one cycle.
- R2: A start is accepted when `start_pulse` is sampled high while no start is outstanding. `start_stamp` then takes the counter value C of that edge, where C equals k for the k-th edge after reset. The new stamp is visible after that edge.
- R3: A done is accepted when `done_pulse` is sampled high while a start is outstanding. On the clock after that edge:
  - `done_stamp` equals C.
  - `latency` equals (C − `start_stamp`) mod 2^CNT_W.
  - `result_valid` is high for exactly that one cycle.
  - No start is outstanding afterwards.
- R4: `interval_valid` is 0 after reset and becomes 1 at the second accepted start. It then stays 1 until reset. At each accepted start after the first, `interval` is updated to (C − previous `start_stamp`) mod 2^CNT_W.
- R5: A start sampled while a start is outstanding is dropped: `start_stamp`, `interval` and `interval_valid` keep their values. `overlap_err` is set and stays 1 until reset.
- R6: A done sampled while no start is outstanding, and without a start in the same cycle, is dropped: no `result_valid` strobe, and `latency` and `done_stamp` keep their values. `orphan_err` is set and stays 1 until reset.
- R7: When start and done are sampled high in the same cycle with no start outstanding, both are accepted. `start_stamp` and `done_stamp` both equal C, `latency` is 0, `result_valid` strobes, and no start is outstanding afterwards.
- R8: When start and done are sampled high in the same cycle with a start already outstanding, the done closes the outstanding start as in R3. The new start is dropped as in R5.
- R9: Synchronous reset clears the counter, all stamps, `latency`, `interval`, `interval_valid`, `result_valid` and both error flags to 0.
- R10: A start-to-done span or start-to-start span that crosses one counter wrap yields the true cycle count, as long as that count is less than 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the measured logic |
| rst | input | 1 | Synchronous reset, active high |
| start_pulse | input | 1 | One-cycle start-of-work strobe |
| done_pulse | input | 1 | One-cycle end-of-work strobe |
| count_out | output | CNT_W | Free-running cycle count, one cycle behind the internal counter |
| start_stamp | output | CNT_W | Counter value at the last accepted start |
| done_stamp | output | CNT_W | Counter value at the last accepted done |
| latency | output | CNT_W | Done stamp minus start stamp, modulo 2^CNT_W |
| interval | output | CNT_W | Start-to-start distance, modulo 2^CNT_W |
| interval_valid | output | 1 | `interval` holds a real measurement |
| result_valid | output | 1 | One-cycle strobe marking a new latency result |
| overlap_err | output | 1 | Sticky: a start arrived while one was outstanding |
| orphan_err | output | 1 | Sticky: a done arrived with no start outstanding |

## Verification
The bench builds the meter with CNT_W = 8, so the counter wraps every 256 cycles. A run of a few thousand cycles therefore crosses the wrap many times, and a directed span from cycle 200 to cycle 300 tests modulo subtraction across the boundary. Random start and done densities are chosen so that overlapping starts, orphan dones and same-cycle pairs all occur often. Directed sequences cover each of these cases from a clean reset, where the sticky flags can be observed on their own.

// File: rtl/lm_pkg.sv
package lm_pkg;
  // Modulo difference of two stamps of the given width.
  function automatic logic [63:0] stamp_diff(input logic [63:0] later,
                                             input logic [63:0] earlier,
                                             input int unsigned w);
    logic [63:0] mask;
    mask = (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
    return (later - earlier) & mask;
  endfunction
endpackage

// File: rtl/lm_counter.sv
module lm_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_now,
  output logic [CNT_W-1:0] cnt_seen
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_now  <= '0;
      cnt_seen <= '0;
    end else begin
      cnt_now  <= cnt_now + 1'b1;
      cnt_seen <= cnt_now;
    end
  end
endmodule

// File: rtl/lm_tracker.sv
module lm_tracker (
  input  logic clk,
  input  logic rst,
  input  logic start_in,
  input  logic done_in,
  output logic take_start,
  output logic take_done,
  output logic busy,
  output logic seen_start,
  output logic overlap,
  output logic orphan
);
  // A start is taken only when nothing is outstanding; a done closes an
  // outstanding start or one opened in the same cycle.
  always_comb begin
    take_start = start_in && !busy;
    take_done  = done_in && (busy || take_start);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      seen_start <= 1'b0;
      overlap    <= 1'b0;
      orphan     <= 1'b0;
    end else begin
      if (take_done)       busy <= 1'b0;
      else if (take_start) busy <= 1'b1;
      if (take_start)            seen_start <= 1'b1;
      if (start_in && busy)      overlap    <= 1'b1;
      if (done_in && !take_done) orphan     <= 1'b1;
    end
  end
endmodule

// File: rtl/lm_delta.sv
module lm_delta #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_now,
  input  logic             take_start,
  input  logic             take_done,
  input  logic             seen_start,
  output logic [CNT_W-1:0] start_stamp,
  output logic [CNT_W-1:0] done_stamp,
  output logic [CNT_W-1:0] latency,
  output logic [CNT_W-1:0] interval,
  output logic             interval_valid,
  output logic             result_valid
);
  logic [CNT_W-1:0] open_stamp;
  logic [CNT_W-1:0] gap_now;

  // Stamp the latency is measured from: this cycle's count if the start is
  // accepted together with the done.
  always_comb begin
    open_stamp = take_start ? cnt_now : start_stamp;
    gap_now    = cnt_now - start_stamp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_stamp    <= '0;
      done_stamp     <= '0;
      latency        <= '0;
      interval       <= '0;
      interval_valid <= 1'b0;
      result_valid   <= 1'b0;
    end else begin
      result_valid <= take_done;
      if (take_start) begin
        start_stamp <= cnt_now;
        if (seen_start) begin
          interval       <= gap_now;
          interval_valid <= 1'b1;
        end
      end
      if (take_done) begin
        done_stamp <= cnt_now;
        latency    <= cnt_now - open_stamp;
      end
    end
  end
endmodule

// File: rtl/latency_meter.sv
module latency_meter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_pulse,
  input  logic             done_pulse,
  output logic [CNT_W-1:0] count_out,
  output logic [CNT_W-1:0] start_stamp,
  output logic [CNT_W-1:0] done_stamp,
  output logic [CNT_W-1:0] latency,
  output logic [CNT_W-1:0] interval,
  output logic             interval_valid,
  output logic             result_valid,
  output logic             overlap_err,
  output logic             orphan_err
);
  logic [CNT_W-1:0] cnt_now;
  logic take_start, take_done, busy, seen_start;

  lm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .cnt_now(cnt_now), .cnt_seen(count_out)
  );

  lm_tracker u_trk (
    .clk(clk), .rst(rst), .start_in(start_pulse), .done_in(done_pulse),
    .take_start(take_start), .take_done(take_done), .busy(busy),
    .seen_start(seen_start), .overlap(overlap_err), .orphan(orphan_err)
  );

  lm_delta #(.CNT_W(CNT_W)) u_dlt (
    .clk(clk), .rst(rst), .cnt_now(cnt_now),
    .take_start(take_start), .take_done(take_done), .seen_start(seen_start),
    .start_stamp(start_stamp), .done_stamp(done_stamp), .latency(latency),
    .interval(interval), .interval_valid(interval_valid),
    .result_valid(result_valid)
  );
endmodule

// File: rtl/latency_meter_chk.sv
module latency_meter_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             start_pulse,
  input logic             done_pulse,
  input logic             busy,
  input logic [CNT_W-1:0] count_out,
  input logic [CNT_W-1:0] latency,
  input logic [CNT_W-1:0] start_stamp,
  input logic             interval_valid,
  input logic             result_valid,
  input logic             overlap_err,
  input logic             orphan_err
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)                age <= 2'd0;
    else if (age != 2'd2)   age <= age + 2'd1;
  end

  a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> count_out == CNT_W'($past(count_out) + 1'b1));

  a_r3_strobe_follows_done: assert property (@(posedge clk) disable iff (rst)
    (done_pulse && busy) |=> result_valid);

  a_r4_interval_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    interval_valid |=> interval_valid);

  a_r5_overlap_sticky: assert property (@(posedge clk) disable iff (rst)
    overlap_err |=> overlap_err);

  a_r5_stamp_kept: assert property (@(posedge clk) disable iff (rst)
    (start_pulse && busy) |=> $stable(start_stamp));

  a_r6_orphan_sticky: assert property (@(posedge clk) disable iff (rst)
    orphan_err |=> orphan_err);

  a_r6_no_strobe_orphan: assert property (@(posedge clk) disable iff (rst)
    (done_pulse && !start_pulse && !busy) |=> !result_valid);

  a_r7_zero_latency: assert property (@(posedge clk) disable iff (rst)
    (start_pulse && done_pulse && !busy) |=> (result_valid && latency == '0));
endmodule

bind latency_meter latency_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start_pulse(start_pulse), .done_pulse(done_pulse),
  .busy(busy), .count_out(count_out), .latency(latency),
  .start_stamp(start_stamp), .interval_valid(interval_valid),
  .result_valid(result_valid), .overlap_err(overlap_err),
  .orphan_err(orphan_err)
);

// File: tb/latency_meter_tb.sv
module latency_meter_tb;
  localparam int unsigned W = 8;
  localparam logic [63:0] MASK = (64'd1 << W) - 64'd1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_pulse = 1'b0;
  logic done_pulse = 1'b0;
  logic [W-1:0] count_out, start_stamp, done_stamp, latency, interval;
  logic interval_valid, result_valid, overlap_err, orphan_err;

  always #2 clk = ~clk;  // 250 MHz

  latency_meter #(.CNT_W(W)) u_dut (
    .clk(clk), .rst(rst), .start_pulse(start_pulse), .done_pulse(done_pulse),
    .count_out(count_out), .start_stamp(start_stamp), .done_stamp(done_stamp),
    .latency(latency), .interval(interval), .interval_valid(interval_valid),
    .result_valid(result_valid), .overlap_err(overlap_err),
    .orphan_err(orphan_err)
  );

  int vectors = 0;
  int miscompares = 0;

  // reference model state
  longint unsigned edge_idx;
  logic m_busy, m_seen, m_ivalid, m_rv, m_ovl, m_orph;
  logic [63:0] m_sts, m_dts, m_lat, m_int;

  function automatic logic [63:0] mdiff(input logic [63:0] a, input logic [63:0] b);
    return (a - b) & MASK;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at edge %0d: actual %0h expected %0h", req, edge_idx, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R1 count_out", 64'(count_out), (edge_idx == 0) ? 64'd0 : ((edge_idx - 1) & MASK));
    chk("R3 result_valid", 64'(result_valid), 64'(m_rv));
    chk("R3 latency", 64'(latency), m_lat);
    chk("R2 start_stamp", 64'(start_stamp), m_sts);
    chk("R3 done_stamp", 64'(done_stamp), m_dts);
    chk("R4 interval_valid", 64'(interval_valid), 64'(m_ivalid));
    chk("R4 interval", 64'(interval), m_int);
    chk("R5 overlap_err", 64'(overlap_err), 64'(m_ovl));
    chk("R6 orphan_err", 64'(orphan_err), 64'(m_orph));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start_pulse = 1'b0; done_pulse = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    edge_idx = 0;
    m_busy = 0; m_seen = 0; m_ivalid = 0; m_rv = 0; m_ovl = 0; m_orph = 0;
    m_sts = 0; m_dts = 0; m_lat = 0; m_int = 0;
    check_all();  // R9 reset state
  endtask

  // Apply one cycle of stimulus; we are at a negedge on entry and exit.
  task automatic step(input logic s, input logic d);
    logic [63:0] c;
    logic ts, td;
    start_pulse = s; done_pulse = d;
    @(posedge clk);
    c  = edge_idx & MASK;
    ts = s && !m_busy;
    td = d && (m_busy || ts);
    if (s && m_busy) m_ovl = 1'b1;
    if (d && !td)    m_orph = 1'b1;
    m_rv = td;
    if (td) begin
      m_lat = ts ? 64'd0 : mdiff(c, m_sts);
      m_dts = c;
    end
    if (ts) begin
      if (m_seen) begin m_int = mdiff(c, m_sts); m_ivalid = 1'b1; end
      m_sts = c; m_seen = 1'b1;
    end
    if (td) m_busy = 1'b0; else if (ts) m_busy = 1'b1;
    edge_idx++;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R9 reset, R1 counting, R6 orphan done
    do_reset();
    repeat (4) step(0, 0);
    step(0, 1);
    step(0, 0);
    // R2 R3 basic latency, R7 same-cycle pair, R4 interval
    do_reset();
    step(1, 0);
    repeat (5) step(0, 0);
    step(0, 1);
    step(0, 0);
    step(1, 1);
    step(0, 0);
    // R5 overlap, R8 pair with outstanding start
    step(1, 0);
    step(0, 0);
    step(1, 0);
    step(1, 1);
    step(0, 0);
    // R10 span across the counter wrap
    do_reset();
    repeat (200) step(0, 0);
    step(1, 0);
    repeat (100) step(0, 0);
    step(0, 1);
    repeat (150) step(0, 0);
    step(1, 0);
    step(0, 1);
    // random phase
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      logic s, d;
      s = ($urandom % 9) == 0;
      d = ($urandom % 6) == 0;
      step(s, d);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule